// File: doc/BRIEF.md
# Interval Timer Latch and Read-Back Front End

This block sits between a byte-wide I/O port and the three counting engines of a programmable interval timer. It decodes writes to the shared control address. It freezes counts and status snapshots on request, and it steers the byte that a read of each counter's data address returns. The counting engines are outside the block. Each one supplies its live 16-bit count, its output pin level, its null-count flag and its six programmed mode bits.

Software can freeze one counter's count with a single-counter latch command. It can also freeze count, status or both on any set of counters with one read-back command, and then read the frozen values back at leisure. Each counter keeps its own pending flags and its own byte-order toggle. Reads, writes and programming aimed at other counters can therefore fall between the two halves of a 16-bit read without disturbing it.

Top module: `pit_readback_front`

## Requirements
- R1: After a synchronous reset, no count or status latch is pending on any counter, every byte toggle is low, and `rd_data` is 0x00.
- R2: A write to address 3 is a control word. Bits[7:6] = 00, 01 or 10 address counter 0, 1 or 2. Bits[7:6] = 11 make the word a read-back command.
- R3: A control word that is not a read-back and has bits[5:4] = 00 freezes the addressed counter's live count on the cycle of the write. Reads of that counter then return the frozen value, even after the live count moves on.
- R4: While a counter holds an unread frozen count, a further count latch request for it has no effect. The same holds for an unread status snapshot and a further status request. Reads return the first captured value.
- R5: In a read-back command, bit 5 low requests a count latch and bit 4 low requests a status latch. Bits 3, 2 and 1 select counters 2, 1 and 0, and every selected counter is served by the same write. Bit 0 is ignored.
- R6: The status byte is {OUT, null-count, mode[5:0]}, with OUT in bit 7. The mode bits are [5:4] access mode, [3:1] counting mode and [0] BCD.
- R7: When a status snapshot and a frozen count are both pending, the next read returns the status byte. The reads after it return the count.
- R8: Access mode 01 returns the low byte only and mode 10 the high byte only, so one read releases a frozen count. Mode 11 returns the low byte and then the high byte, and the frozen count is released only after the high byte.
- R9: Each counter tracks its next byte separately. Accesses to other counters between the two reads of a 16-bit value do not change the bytes returned.
- R10: With nothing pending, a read returns the live count, byte-ordered as in R8.
- R11: A control word that is not a read-back and has bits[5:4] other than 00 programs the addressed counter. It clears that counter's pending latches and its byte toggle.
- R12: `rd_data` is registered and shows a read's byte one clock after `rd_en`. A read of the control address returns 0x00, and `rd_data` holds its value while no read occurs.
- R13: A latch request in the same cycle as the read that releases a frozen count (or status) is accepted. That read returns the old value, and the next read returns the newly captured one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address (0-2 counters, 3 control) |
| wr_data | input | 8 | Write data byte |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address (0-2 counters, 3 control) |
| live_count | input | 48 | Live counts, counter i in bits [16i+15:16i] |
| live_out | input | 3 | Output pin level per counter |
| live_null | input | 3 | Null-count flag per counter |
| live_mode | input | 18 | Programmed mode bits per counter, 6 bits each |
| rd_data | output | 8 | Registered read data |
| cnt_pend | output | 3 | Frozen count pending per counter |
| stat_pend | output | 3 | Status snapshot pending per counter |
| byte_hi | output | 3 | Per-counter toggle: high byte comes next |

## Verification
A data read and a control write can reach the same counter in one clock. The case that matters is a read that consumes the last byte of a frozen count while a new latch command for that counter arrives. The bench drives `rd_en` and a control write on the same falling edge. It then checks three things: that the read returns the old frozen byte, that the pending flag stays set, and that the following read returns the count present at that edge. A second collision pairs a status read with a pending count, to confirm that the count survives the status read.

// File: rtl/pit_fe_pkg.sv
package pit_fe_pkg;

  // access field of a counter's mode bits
  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_WORD = 2'b11
  } acc_e;

  // control word selector value that marks a read-back command
  localparam logic [1:0] SEL_READBACK = 2'b11;

  function automatic logic [7:0] pick_byte(input logic [15:0] v, input logic hi);
    return hi ? v[15:8] : v[7:0];
  endfunction

endpackage

// File: rtl/pit_ctl_decode.sv
module pit_ctl_decode #(
  parameter int CH     = 3,
  parameter int ADDR_W = 2,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [CH-1:0]     cnt_req,
  output logic [CH-1:0]     stat_req,
  output logic [CH-1:0]     prog
);
  import pit_fe_pkg::*;

  localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(CH);

  logic       ctl_wr;
  logic [1:0] sel;
  logic       is_rb;
  logic       rb_cnt, rb_stat;

  assign ctl_wr  = wr_en && (wr_addr == CTL_ADDR);
  assign sel     = wr_data[BYTE_W-1 -: 2];
  assign is_rb   = (sel == SEL_READBACK);
  assign rb_cnt  = ~wr_data[5];
  assign rb_stat = ~wr_data[4];

  for (genvar i = 0; i < CH; i++) begin : g_dec
    logic hit;
    logic rb_sel;
    assign hit    = (sel == 2'(i));
    assign rb_sel = wr_data[i+1];
    always_comb begin
      cnt_req[i]  = 1'b0;
      stat_req[i] = 1'b0;
      prog[i]     = 1'b0;
      if (ctl_wr) begin
        if (is_rb) begin
          cnt_req[i]  = rb_sel && rb_cnt;
          stat_req[i] = rb_sel && rb_stat;
        end else if (hit) begin
          if (wr_data[5:4] == 2'b00) cnt_req[i] = 1'b1;
          else                       prog[i]    = 1'b1;
        end
      end
    end
  end

  // R2
  decode_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(prog | cnt_req) || is_rb);

  // R11
  prog_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (prog & (cnt_req | stat_req)) == '0);

endmodule

// File: rtl/pit_chan_port.sv
module pit_chan_port #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*BYTE_W-1:0] live_count,
  input  logic                live_out,
  input  logic                live_null,
  input  logic [BYTE_W-3:0]   live_mode,
  input  logic                cnt_req,
  input  logic                stat_req,
  input  logic                prog,
  input  logic                rd_hit,
  output logic [BYTE_W-1:0]   rd_byte,
  output logic                cnt_pend,
  output logic                stat_pend,
  output logic                hi_next
);
  import pit_fe_pkg::*;

  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] stat_q;
  acc_e              acc;
  logic              word;
  logic              cur_hi;
  logic [CNT_W-1:0]  src;
  logic              cnt_rd, cnt_rel, stat_rel;
  logic              cnt_take, stat_take;

  assign acc    = acc_e'(live_mode[BYTE_W-3 -: 2]);
  assign word   = !(acc == ACC_LO || acc == ACC_HI);
  assign cur_hi = (acc == ACC_HI) ? 1'b1 : (acc == ACC_LO) ? 1'b0 : hi_next;
  assign src    = cnt_pend ? cnt_q : live_count;

  always_comb begin
    if (stat_pend) rd_byte = stat_q;
    else           rd_byte = pick_byte(src, cur_hi);
  end

  assign cnt_rd    = rd_hit && !stat_pend;
  assign cnt_rel   = cnt_rd && cnt_pend && (!word || hi_next);
  assign stat_rel  = rd_hit && stat_pend;
  assign cnt_take  = cnt_req && (!cnt_pend || cnt_rel);
  assign stat_take = stat_req && (!stat_pend || stat_rel);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      stat_q    <= '0;
      cnt_pend  <= 1'b0;
      stat_pend <= 1'b0;
      hi_next   <= 1'b0;
    end else if (prog) begin
      cnt_pend  <= 1'b0;
      stat_pend <= 1'b0;
      hi_next   <= 1'b0;
    end else begin
      if (cnt_rd && word) hi_next <= ~hi_next;
      if (cnt_take) begin
        cnt_q    <= live_count;
        cnt_pend <= 1'b1;
      end else if (cnt_rel) begin
        cnt_pend <= 1'b0;
      end
      if (stat_take) begin
        stat_q    <= {live_out, live_null, live_mode};
        stat_pend <= 1'b1;
      end else if (stat_rel) begin
        stat_pend <= 1'b0;
      end
    end
  end

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_pend && !cnt_rel && !prog |=> cnt_pend && $stable(cnt_q));

  // R7
  stat_first_chk: assert property (@(posedge clk) disable iff (rst)
    rd_hit && stat_pend && cnt_pend && !prog |=> cnt_pend);

  // R8
  single_rel_chk: assert property (@(posedge clk) disable iff (rst)
    rd_hit && !stat_pend && cnt_pend && !word && !cnt_req && !prog |=> !cnt_pend);

  // R11
  prog_clear_chk: assert property (@(posedge clk) disable iff (rst)
    prog |=> !cnt_pend && !stat_pend && !hi_next);

endmodule

// File: rtl/pit_rd_mux.sv
module pit_rd_mux #(
  parameter int CH     = 3,
  parameter int ADDR_W = 2,
  parameter int BYTE_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  input  logic [CH*BYTE_W-1:0] chan_bytes,
  output logic [CH-1:0]        rd_hit,
  output logic [BYTE_W-1:0]    rd_data
);
  logic [BYTE_W-1:0] sel_byte;

  for (genvar i = 0; i < CH; i++) begin : g_hit
    assign rd_hit[i] = rd_en && (rd_addr == ADDR_W'(i));
  end

  always_comb begin
    sel_byte = '0;
    for (int i = 0; i < CH; i++)
      if (rd_hit[i]) sel_byte = chan_bytes[i*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel_byte;
  end

  // R12
  ctl_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && (rd_hit == '0) |=> rd_data == '0);

  // R12
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/pit_readback_front.sv
module pit_readback_front #(
  parameter int CH     = 3,
  parameter int ADDR_W = 2,
  parameter int BYTE_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [BYTE_W-1:0]      wr_data,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [CH*2*BYTE_W-1:0] live_count,
  input  logic [CH-1:0]          live_out,
  input  logic [CH-1:0]          live_null,
  input  logic [CH*(BYTE_W-2)-1:0] live_mode,
  output logic [BYTE_W-1:0]      rd_data,
  output logic [CH-1:0]          cnt_pend,
  output logic [CH-1:0]          stat_pend,
  output logic [CH-1:0]          byte_hi
);
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int MODE_W = BYTE_W - 2;

  logic [CH-1:0]        cnt_req, stat_req, prog, rd_hit;
  logic [CH*BYTE_W-1:0] chan_bytes;

  pit_ctl_decode #(.CH(CH), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_req(cnt_req), .stat_req(stat_req), .prog(prog)
  );

  for (genvar i = 0; i < CH; i++) begin : g_ch
    pit_chan_port #(.BYTE_W(BYTE_W)) u_ch (
      .clk(clk), .rst(rst),
      .live_count(live_count[i*CNT_W +: CNT_W]),
      .live_out(live_out[i]),
      .live_null(live_null[i]),
      .live_mode(live_mode[i*MODE_W +: MODE_W]),
      .cnt_req(cnt_req[i]), .stat_req(stat_req[i]), .prog(prog[i]),
      .rd_hit(rd_hit[i]),
      .rd_byte(chan_bytes[i*BYTE_W +: BYTE_W]),
      .cnt_pend(cnt_pend[i]), .stat_pend(stat_pend[i]), .hi_next(byte_hi[i])
    );
  end

  pit_rd_mux #(.CH(CH), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_mux (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .chan_bytes(chan_bytes), .rd_hit(rd_hit), .rd_data(rd_data)
  );

endmodule

// File: tb/pit_readback_front_test.sv
module pit_readback_front_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en, rd_en;
  logic [1:0]  wr_addr, rd_addr;
  logic [7:0]  wr_data;
  logic [47:0] live_count;
  logic [2:0]  live_out, live_null;
  logic [17:0] live_mode;
  logic [7:0]  rd_data;
  logic [2:0]  cnt_pend, stat_pend, byte_hi;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pit_readback_front uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .live_count(live_count),
    .live_out(live_out), .live_null(live_null), .live_mode(live_mode),
    .rd_data(rd_data), .cnt_pend(cnt_pend), .stat_pend(stat_pend), .byte_hi(byte_hi)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic set_live(input int ch, input logic [15:0] v);
    live_count[ch*16 +: 16] = v;
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 pend", {2'b0, cnt_pend, stat_pend}, 8'h00);
    chk("R1 toggle", {5'b0, byte_hi}, 8'h00);
  endtask

  task automatic t_live();
    logic [7:0] d;
    set_live(0, 16'h1234); set_live(1, 16'hABCD); set_live(2, 16'h5678);
    rd(0, d); chk("R10 live lo", d, 8'h34);
    rd(0, d); chk("R10 live hi", d, 8'h12);
    rd(1, d); chk("R8 lo-only", d, 8'hCD);
    rd(1, d); chk("R8 lo-only again", d, 8'hCD);
    rd(2, d); chk("R8 hi-only", d, 8'h56);
    repeat (3) @(negedge clk);
    chk("R12 hold", rd_data, 8'h56);
    rd(3, d); chk("R12 ctl read", d, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] d;
    set_live(0, 16'h1234);
    wr_ctl(8'h00);
    set_live(0, 16'h9999);
    chk("R3 pend", {7'b0, cnt_pend[0]}, 8'h01);
    wr_ctl(8'h00);
    rd(0, d); chk("R4 first lo", d, 8'h34);
    rd(0, d); chk("R4 first hi", d, 8'h12);
    chk("R8 released", {7'b0, cnt_pend[0]}, 8'h00);
    rd(0, d); chk("R10 live after", d, 8'h99);
  endtask

  task automatic t_interleave();
    logic [7:0] d;
    rd(0, d);
    set_live(0, 16'hA1B2); set_live(1, 16'h4321);
    wr_ctl(8'h00);
    rd(0, d); chk("R9 ch0 lo", d, 8'hB2);
    wr_ctl(8'h40);
    rd(1, d); chk("R9 ch1 lo", d, 8'h21);
    chk("R8 ch1 one read", {7'b0, cnt_pend[1]}, 8'h00);
    rd(3, d);
    rd(0, d); chk("R9 ch0 hi", d, 8'hA1);
  endtask

  task automatic t_readback();
    logic [7:0] d;
    set_live(0, 16'h0F0E); set_live(2, 16'h3344);
    live_out = 3'b001; live_null = 3'b100;
    wr_ctl(8'hCB);
    set_live(0, 16'h0000); set_live(2, 16'h0000);
    live_out = 3'b000; live_null = 3'b000;
    chk("R5 stat sel", {5'b0, stat_pend}, 8'h05);
    chk("R5 cnt sel", {5'b0, cnt_pend}, 8'h05);
    rd(0, d); chk("R6 R7 ch0 status", d, 8'hB4);
    rd(0, d); chk("R7 ch0 lo", d, 8'h0E);
    rd(0, d); chk("R7 ch0 hi", d, 8'h0F);
    rd(2, d); chk("R6 ch2 status", d, 8'h60);
    rd(2, d); chk("R8 ch2 hi", d, 8'h33);
    chk("R5 released", {5'b0, cnt_pend, stat_pend} & 8'h3F, 8'h00);
    set_live(1, 16'h7788);
    wr_ctl(8'hD4);
    chk("R5 count only", {6'b0, stat_pend[1], cnt_pend[1]}, 8'h01);
    set_live(1, 16'h0000);
    rd(1, d); chk("R5 ch1 frozen", d, 8'h88);
    live_out = 3'b001;
    wr_ctl(8'hE2);
    live_out = 3'b000;
    wr_ctl(8'hE2);
    chk("R5 status only", {6'b0, stat_pend[0], cnt_pend[0]}, 8'h02);
    rd(0, d); chk("R4 status first kept", d, 8'hB4);
  endtask

  task automatic t_prog();
    logic [7:0] d;
    set_live(0, 16'h5A6B);
    wr_ctl(8'h00);
    rd(0, d);
    chk("R9 toggle mid", {7'b0, byte_hi[0]}, 8'h01);
    wr_ctl(8'h34);
    chk("R11 cleared", {6'b0, byte_hi[0], cnt_pend[0]}, 8'h00);
    set_live(0, 16'hC0DE);
    rd(0, d); chk("R11 live lo", d, 8'hDE);
    rd(0, d);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    set_live(2, 16'h1200);
    wr_ctl(8'h80);
    set_live(2, 16'h3400);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 2'd2;
    wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h80;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    chk("R13 old byte", rd_data, 8'h12);
    chk("R13 still pend", {7'b0, cnt_pend[2]}, 8'h01);
    set_live(2, 16'h0000);
    rd(2, d); chk("R13 new byte", d, 8'h34);
  endtask

  initial begin
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    wr_addr = '0; rd_addr = '0; wr_data = '0;
    live_count = '0; live_out = '0; live_null = '0;
    // ch0 word access mode 2, ch1 low-only mode 3 bcd, ch2 high-only mode 0
    live_mode = {6'b10_000_0, 6'b01_011_1, 6'b11_010_0};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_live();
    t_latch();
    t_interleave();
    t_readback();
    t_prog();
    t_same_cycle();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule